// File: doc/BRIEF.md
# Raster Sync and Blanking Sequencer

This block produces the horizontal sync, vertical sync and active-video qualifier for a raster display, together with the current pixel column and line numbers and one-clock markers for the start of each line and each frame. It runs entirely on the system clock. A fractional phase accumulator turns an 8.8 fixed-point clock ratio into a pixel-enable strobe, and every counter in the block advances only on that strobe.

Timing is programmed as two packed 32-bit descriptor words, one per axis, plus a divisor word. All three are written through a small register port into shadow copies, and they are copied into the working set only at the boundary between two frames. A frame that has started is therefore never torn. Each axis is a four-state machine whose states are PH_ACTIVE, PH_FRONT, PH_SYNC and PH_BACK. The transitions are: ACTIVE to FRONT when the active count is used up, FRONT to SYNC when the front porch ends, SYNC to BACK when the sync pulse ends, and BACK back to ACTIVE (wrap) when the back porch ends. Any state whose programmed length is zero is passed over on the way. The vertical machine steps once per horizontal wrap.

Top module: `raster_timing_gen`

## Requirements
- R1: The horizontal word is decoded as follows. Bits 7:0 hold the active width in units of 8 pixels. Bits 15:8 hold the back porch, bits 23:16 the sync width and bits 30:24 the front porch, all in pixels. A line consists of active, front porch, sync and back porch in that order, and its length is the sum of the four.
- R2: The vertical word is decoded as follows. Bits 10:0 hold the visible lines, bits 19:11 the back porch, bits 22:20 the sync width and bits 30:23 the front porch, all in lines. A frame uses the same phase order, and its line count is the sum of the four fields.
- R3: Bit 31 of each axis word sets that axis's sync polarity. A value of 1 makes the pulse active-low, so the output idles high. A value of 0 makes the pulse active-high.
- R4: The low 16 bits of the divisor word give system clocks per pixel in 8.8 fixed point. Counting from the first clock of a frame as clock 1, the k-th pixel strobe falls on clock ceil(k*div/256). With an integer ratio, strobes are therefore evenly spaced at div/256 clocks.
- R5: A divisor below 256 (below 1.0) behaves exactly as 256, giving one pixel per system clock.
- R6: A phase programmed with length zero is skipped entirely. It takes no pixels or lines and does not wrap the counter.
- R7: The line counter steps once per line, when the horizontal back porch (the last non-empty phase) ends. Vertical sync covers whole lines.
- R8: x is the pixel index within the line, starting from 0. y is the line index within the frame, starting from 0. `active` is high only when both axes are in their active phase.
- R9: `line_start` is high for the single system clock in which a new line begins, with x equal to 0. `frame_start` is high for the single clock in which a new frame begins, and `line_start` is also high in that clock.
- R10: The write port has three addresses. Address 0 is the horizontal word, address 1 the vertical word and address 2 the divisor. Address 3 is ignored. Writes land in shadow registers and take effect only at the next frame start.
- R11: Reset loads the parameter default words into both the shadow and working sets. It clears the accumulator and places both axes at position 0 in their first non-empty phase, with both start markers low.
- R12: The 800-column mode (porches/sync 8/64/8) gives 880 pixels per line. Vertical settings 1/2/22 with 600 lines give 625 lines. The 640-column mode gives 720 pixels per line, and 1/2/93 with 400 lines gives 496 lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 horizontal, 1 vertical, 2 divisor |
| wr_data | input | 32 | Write data |
| pix_stb | output | 1 | Pixel-enable strobe, one system clock wide |
| hsync | output | 1 | Horizontal sync at programmed polarity |
| vsync | output | 1 | Vertical sync at programmed polarity |
| active | output | 1 | Both axes in their active region |
| x | output | POS_W | Pixel index within the line |
| y | output | POS_W | Line index within the frame |
| line_start | output | 1 | First clock of each line |
| frame_start | output | 1 | First clock of each frame |

## Verification
The bench measures whole frames for both reference modes, alternating each with a very short opposite axis so that the run stays short. A wrong field offset or width would show up as a sync pulse at the wrong pixel, a wrong pulse width, or a wrong line total. A reversed polarity bit would make the pulse count come out as the line length minus the sync width. A configuration with empty porches checks that a zero-length phase is skipped rather than wrapping the counter through 4095. Fractional and clamped divisors are checked through the exact clock count per frame, so an accumulator that drops its remainder or lets a divisor below 1.0 through would fail. A descriptor written just after a frame begins must leave that frame's length unchanged, which catches any design that applies writes immediately.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    localparam int LEN_W = 12;
    localparam int NPH   = 4;

    typedef enum logic [1:0] {
        PH_ACTIVE = 2'd0,
        PH_FRONT  = 2'd1,
        PH_SYNC   = 2'd2,
        PH_BACK   = 2'd3
    } phase_t;

    typedef logic [NPH-1:0][LEN_W-1:0] len_set_t;

    localparam logic [1:0] WA_HORZ = 2'd0;
    localparam logic [1:0] WA_VERT = 2'd1;
    localparam logic [1:0] WA_DIV  = 2'd2;

    // Horizontal descriptor: active width is stored in groups of eight pixels.
    function automatic len_set_t h_lengths(input logic [30:0] w);
        len_set_t l;
        l[PH_ACTIVE] = LEN_W'({w[7:0], 3'b000});
        l[PH_FRONT]  = LEN_W'(w[30:24]);
        l[PH_SYNC]   = LEN_W'(w[23:16]);
        l[PH_BACK]   = LEN_W'(w[15:8]);
        return l;
    endfunction

    function automatic len_set_t v_lengths(input logic [30:0] w);
        len_set_t l;
        l[PH_ACTIVE] = LEN_W'(w[10:0]);
        l[PH_FRONT]  = LEN_W'(w[30:23]);
        l[PH_SYNC]   = LEN_W'(w[22:20]);
        l[PH_BACK]   = LEN_W'(w[19:11]);
        return l;
    endfunction

    // Nearest non-empty phase after p; bit 2 says whether one exists.
    function automatic logic [2:0] next_live(input len_set_t l, input phase_t p);
        logic [2:0] r;
        r = 3'b000;
        for (int i = NPH - 1; i >= 0; i--) begin
            if (i > int'(p) && l[i] != '0) r = {1'b1, 2'(i)};
        end
        return r;
    endfunction

    // First non-empty phase of a period; ACTIVE when everything is empty.
    function automatic phase_t first_live(input len_set_t l);
        phase_t r;
        r = PH_ACTIVE;
        for (int i = NPH - 1; i >= 0; i--) begin
            if (l[i] != '0) r = phase_t'(2'(i));
        end
        return r;
    endfunction

endpackage

// File: rtl/rtg_pixel_strobe.sv
module rtg_pixel_strobe #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             stb
);
    localparam int SUM_W = DIV_W + 1;
    localparam logic [SUM_W-1:0] UNIT = SUM_W'(1) << FRAC_W;

    logic [DIV_W-1:0] acc_q;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] div_eff;

    always_comb begin
        div_eff = {1'b0, div};
        if (div_eff < UNIT) div_eff = UNIT;
        sum = {1'b0, acc_q} + UNIT;
        stb = (sum >= div_eff);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
        end else if (stb) begin
            acc_q <= DIV_W'(sum - div_eff);
        end else begin
            acc_q <= DIV_W'(sum);
        end
    end

endmodule

// File: rtl/rtg_axis_seq.sv
module rtg_axis_seq
    import rtg_pkg::*;
#(
    parameter int       POS_W   = 12,
    parameter len_set_t RST_LEN = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  len_set_t         cur_len,
    input  len_set_t         nxt_len,
    output phase_t           phase,
    output logic [POS_W-1:0] pos,
    output logic             wrap
);
    localparam phase_t RST_PH = first_live(RST_LEN);

    phase_t           ph_q, ph_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    logic [POS_W-1:0] pos_q, pos_d;
    logic [LEN_W-1:0] ph_len;
    logic [2:0]       ahead;
    logic             last;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= RST_PH;
            cnt_q <= '0;
            pos_q <= '0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
            pos_q <= pos_d;
        end
    end

    // Next state.
    always_comb begin
        unique case (ph_q)
            PH_ACTIVE: ph_len = cur_len[PH_ACTIVE];
            PH_FRONT:  ph_len = cur_len[PH_FRONT];
            PH_SYNC:   ph_len = cur_len[PH_SYNC];
            PH_BACK:   ph_len = cur_len[PH_BACK];
            default:   ph_len = cur_len[PH_ACTIVE];
        endcase
        ahead = next_live(cur_len, ph_q);
        last  = (cnt_q == ph_len - LEN_W'(1));
        wrap  = last && !ahead[2];

        ph_d  = ph_q;
        cnt_d = cnt_q;
        pos_d = pos_q;
        if (step) begin
            if (last) begin
                cnt_d = '0;
                if (ahead[2]) begin
                    ph_d  = phase_t'(ahead[1:0]);
                    pos_d = pos_q + POS_W'(1);
                end else begin
                    ph_d  = first_live(nxt_len);
                    pos_d = '0;
                end
            end else begin
                cnt_d = cnt_q + LEN_W'(1);
                pos_d = pos_q + POS_W'(1);
            end
        end
    end

    assign phase = ph_q;
    assign pos   = pos_q;

endmodule

// File: rtl/rtg_cfg_regs.sv
module rtg_cfg_regs
    import rtg_pkg::*;
#(
    parameter logic [31:0] DEF_H = 32'h8840_0850,
    parameter logic [31:0] DEF_V = 32'h80A2_E990,
    parameter logic [15:0] DEF_D = 16'h0A00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        load,
    output logic [31:0] sh_h,
    output logic [31:0] sh_v,
    output logic [31:0] cur_h,
    output logic [31:0] cur_v,
    output logic [15:0] cur_d
);
    logic [15:0] sh_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_h <= DEF_H;
            sh_v <= DEF_V;
            sh_d <= DEF_D;
        end else if (wr_en) begin
            unique case (wr_addr)
                WA_HORZ: sh_h <= wr_data;
                WA_VERT: sh_v <= wr_data;
                WA_DIV:  sh_d <= wr_data[15:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_h <= DEF_H;
            cur_v <= DEF_V;
            cur_d <= DEF_D;
        end else if (load) begin
            cur_h <= sh_h;
            cur_v <= sh_v;
            cur_d <= sh_d;
        end
    end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int          POS_W = 12,
    parameter logic [31:0] DEF_H = 32'h8840_0850,
    parameter logic [31:0] DEF_V = 32'h80A2_E990,
    parameter logic [15:0] DEF_D = 16'h0A00
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [31:0]      wr_data,
    output logic             pix_stb,
    output logic             hsync,
    output logic             vsync,
    output logic             active,
    output logic [POS_W-1:0] x,
    output logic [POS_W-1:0] y,
    output logic             line_start,
    output logic             frame_start
);
    localparam len_set_t H_RST = h_lengths(DEF_H[30:0]);
    localparam len_set_t V_RST = v_lengths(DEF_V[30:0]);

    logic [31:0] sh_h, sh_v, cur_h, cur_v;
    logic [15:0] cur_d;
    len_set_t    h_len, v_len, h_nxt, v_nxt;
    phase_t      h_ph, v_ph;
    logic        h_wrap, v_wrap, line_end, frame_end;

    rtg_cfg_regs #(.DEF_H(DEF_H), .DEF_V(DEF_V), .DEF_D(DEF_D)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (frame_end),
        .sh_h    (sh_h),
        .sh_v    (sh_v),
        .cur_h   (cur_h),
        .cur_v   (cur_v),
        .cur_d   (cur_d)
    );

    rtg_pixel_strobe #(.DIV_W(16), .FRAC_W(8)) u_stb (
        .clk (clk),
        .rst (rst),
        .clr (frame_end),
        .div (cur_d),
        .stb (pix_stb)
    );

    always_comb begin
        h_len = h_lengths(cur_h[30:0]);
        v_len = v_lengths(cur_v[30:0]);
        v_nxt = v_lengths(sh_v[30:0]);
        h_nxt = v_wrap ? h_lengths(sh_h[30:0]) : h_len;
    end

    assign line_end  = pix_stb && h_wrap;
    assign frame_end = line_end && v_wrap;

    rtg_axis_seq #(.POS_W(POS_W), .RST_LEN(H_RST)) u_h (
        .clk     (clk),
        .rst     (rst),
        .step    (pix_stb),
        .cur_len (h_len),
        .nxt_len (h_nxt),
        .phase   (h_ph),
        .pos     (x),
        .wrap    (h_wrap)
    );

    rtg_axis_seq #(.POS_W(POS_W), .RST_LEN(V_RST)) u_v (
        .clk     (clk),
        .rst     (rst),
        .step    (line_end),
        .cur_len (v_len),
        .nxt_len (v_nxt),
        .phase   (v_ph),
        .pos     (y),
        .wrap    (v_wrap)
    );

    // Outputs derived from the two phase machines.
    always_comb begin
        hsync  = (h_ph == PH_SYNC) ^ cur_h[31];
        vsync  = (v_ph == PH_SYNC) ^ cur_v[31];
        active = (h_ph == PH_ACTIVE) && (v_ph == PH_ACTIVE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_start  <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            line_start  <= line_end;
            frame_start <= frame_end;
        end
    end

endmodule

// File: rtl/rtg_checks.sv
module rtg_checks #(
    parameter int POS_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             pix_stb,
    input logic             line_start,
    input logic             frame_start,
    input logic             active,
    input logic [POS_W-1:0] x,
    input logic [POS_W-1:0] y,
    input logic [31:0]      cur_h,
    input logic [31:0]      cur_v,
    input logic [15:0]      cur_d
);
    // R9: every frame start is also a line start
    a_r9_frame_has_line: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> line_start);

    // R9: a line begins at column zero
    a_r9_line_origin: assert property (@(posedge clk) disable iff (rst)
        line_start |-> (x == '0));

    // R9: a frame begins on line zero
    a_r9_frame_origin: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (y == '0));

    // R4: positions hold between pixel strobes
    a_r4_hold_between: assert property (@(posedge clk) disable iff (rst)
        !pix_stb |=> ($stable(x) && $stable(y)));

    // R8: active only inside the programmed visible window
    a_r8_active_inside: assert property (@(posedge clk) disable iff (rst)
        active |-> ((POS_W'(x) < POS_W'({cur_h[7:0], 3'b000})) && (y < POS_W'(cur_v[10:0]))));

    // R10: working configuration changes only as a frame begins
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        !frame_start |-> ($stable(cur_h) && $stable(cur_v) && $stable(cur_d)));

endmodule

bind raster_timing_gen rtg_checks #(.POS_W(POS_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pix_stb     (pix_stb),
    .line_start  (line_start),
    .frame_start (frame_start),
    .active      (active),
    .x           (x),
    .y           (y),
    .cur_h       (cur_h),
    .cur_v       (cur_v),
    .cur_d       (cur_d)
);

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;

    localparam logic [31:0] H800 = 32'h8840_0864;
    localparam logic [31:0] H640 = 32'h8840_0850;
    localparam logic [31:0] HT   = 32'h8101_0101;
    localparam logic [31:0] HZ   = 32'h0003_0002;
    localparam logic [31:0] V600 = 32'h80A0_B258;
    localparam logic [31:0] V400 = 32'h80A2_E990;
    localparam logic [31:0] VT   = 32'h8090_0802;
    localparam logic [31:0] VZ   = 32'h0010_0003;
    localparam int NV = 10;

    // {hword, vword, divisor, expected line length, expected line count}
    localparam logic [127:0] VEC [NV] = '{
        {H800, VT,   32'h0100, 16'd880, 16'd5},
        {H640, VT,   32'h0100, 16'd720, 16'd5},
        {HT,   V600, 32'h0100, 16'd11,  16'd625},
        {HT,   V400, 32'h0100, 16'd11,  16'd496},
        {HZ,   VZ,   32'h0100, 16'd19,  16'd4},
        {HT,   VT,   32'h0280, 16'd11,  16'd5},
        {HT,   VT,   32'h0080, 16'd11,  16'd5},
        {HT,   VT,   32'h0A00, 16'd11,  16'd5},
        {H640, VZ,   32'h0A00, 16'd720, 16'd4},
        {H800, VZ,   32'h0A00, 16'd880, 16'd4}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic        pix_stb, hsync, vsync, active, line_start, frame_start;
    logic [11:0] x, y;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    raster_timing_gen #(.POS_W(12), .DEF_H(HT), .DEF_V(VT), .DEF_D(16'h0100)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .pix_stb     (pix_stb),
        .hsync       (hsync),
        .vsync       (vsync),
        .active      (active),
        .x           (x),
        .y           (y),
        .line_start  (line_start),
        .frame_start (frame_start)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_sof();
        int n;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!frame_start && n < 100000);
    endtask

    // Walks one frame starting at a negedge where frame_start is high.
    task automatic run_frame(input int width, input int vis, input logic hon, input logic von,
                             output int clks, output int pix, output int lines,
                             output int hs_first, output int hs_cnt,
                             output int vs_first, output int vs_cnt,
                             output int act_cnt, output int bad,
                             output int gmin, output int gmax);
        int line_pix;
        int gap;
        clks = 0; pix = 0; lines = 0; hs_first = -1; hs_cnt = 0;
        vs_first = -1; vs_cnt = 0; act_cnt = 0; bad = 0;
        gmin = 1 << 30; gmax = 0; gap = 0; line_pix = 0;
        do begin
            clks++;
            gap++;
            if (line_start) begin
                lines++;
                line_pix = 0;
                if (x != 0) bad++;
            end
            if (pix_stb) begin
                if (int'(x) != line_pix || int'(y) != lines - 1) bad++;
                if (lines == 1 && hsync == hon) begin
                    if (hs_cnt == 0) hs_first = line_pix;
                    hs_cnt++;
                end
                if (vsync == von) begin
                    if (vs_cnt == 0) vs_first = pix;
                    vs_cnt++;
                end
                if (active) begin
                    act_cnt++;
                    if (int'(x) >= width || int'(y) >= vis) bad++;
                end
                if (gap < gmin) gmin = gap;
                if (gap > gmax) gmax = gap;
                gap = 0;
                pix++;
                line_pix++;
            end
            @(negedge clk);
        end while (!frame_start && clks < 100000);
    endtask

    task automatic run_vector(input int i);
        logic [31:0] hw, vw, dw;
        int ht_tab, vt_tab, hwid, hfp, hsw, hbp, vis, vfp, vsw, vbp, ht, vt, deff;
        int clks, pix, lines, hs_first, hs_cnt, vs_first, vs_cnt, act_cnt, bad, gmin, gmax;
        longint exp_clk;
        hw = VEC[i][127:96]; vw = VEC[i][95:64]; dw = VEC[i][63:32];
        ht_tab = int'(VEC[i][31:16]); vt_tab = int'(VEC[i][15:0]);
        hwid = 8 * int'(hw[7:0]); hfp = int'(hw[30:24]); hsw = int'(hw[23:16]); hbp = int'(hw[15:8]);
        vis = int'(vw[10:0]); vfp = int'(vw[30:23]); vsw = int'(vw[22:20]); vbp = int'(vw[19:11]);
        ht = hwid + hfp + hsw + hbp;
        vt = vis + vfp + vsw + vbp;
        deff = (int'(dw[15:0]) < 256) ? 256 : int'(dw[15:0]);

        do_reset();
        wr(2'd0, hw);
        wr(2'd1, vw);
        wr(2'd2, dw);
        wait_sof();
        chk(frame_start && line_start, "R9", "frame start with line start", frame_start, 1);
        run_frame(hwid, vis, !hw[31], !vw[31], clks, pix, lines, hs_first, hs_cnt,
                  vs_first, vs_cnt, act_cnt, bad, gmin, gmax);

        chk(ht == ht_tab && vt == vt_tab, "R12", "table totals", ht * 10000 + vt, ht_tab * 10000 + vt_tab);
        chk(pix == ht * vt, "R1", "pixels per frame", pix, ht * vt);
        chk(lines == vt, "R2", "lines per frame", lines, vt);
        chk(hs_first == hwid + hfp, "R1", "hsync start pixel", hs_first, hwid + hfp);
        chk(hs_cnt == hsw, "R3", "hsync width at polarity", hs_cnt, hsw);
        chk(vs_first == (vis + vfp) * ht, "R7", "vsync start pixel", vs_first, (vis + vfp) * ht);
        chk(vs_cnt == vsw * ht, "R3", "vsync whole lines at polarity", vs_cnt, vsw * ht);
        chk(act_cnt == hwid * vis, "R8", "active pixels", act_cnt, hwid * vis);
        chk(bad == 0, "R8", "position or window errors", bad, 0);
        exp_clk = (longint'(pix) * deff + 255) / 256;
        chk(clks == exp_clk, (int'(dw[15:0]) < 256) ? "R5" : "R4", "clocks per frame", clks, exp_clk);
        if (deff % 256 == 0) begin
            chk(gmin == deff / 256 && gmax == deff / 256, "R4", "pixel period", gmax * 1000 + gmin,
                (deff / 256) * 1001);
        end
        if (i == 4) begin
            chk(pix == 76 && hs_first == 16, "R6", "empty phases skipped", pix, 76);
        end
    endtask

    initial begin
        int clks, pix, lines, hs_first, hs_cnt, vs_first, vs_cnt, act_cnt, bad, gmin, gmax;
        int pc, n;
        // Reset state, R11: tiny default mode, active-low syncs idle high
        repeat (3) @(negedge clk);
        chk(x == 0 && y == 0, "R11", "reset position", x + y, 0);
        chk(line_start == 0 && frame_start == 0, "R11", "reset markers", line_start + frame_start, 0);
        chk(active == 1, "R11", "reset in active phase", active, 1);
        chk(hsync == 1 && vsync == 1, "R11", "reset sync idle level", hsync + vsync, 2);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) run_vector(i);

        // R10: write at the very start of a frame must not affect that frame
        do_reset();
        wait_sof();
        pc = 0;
        n = 0;
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = HZ;
        do begin
            if (pix_stb) pc++;
            @(negedge clk);
            n++;
            if (n == 1) begin
                wr_addr = 2'd3; wr_data = 32'hFFFF_FFFF;
            end else begin
                wr_en = 1'b0;
            end
        end while (!frame_start && n < 100000);
        chk(pc == 55, "R10", "running frame untouched", pc, 55);
        run_frame(16, 2, 1'b1, 1'b0, clks, pix, lines, hs_first, hs_cnt,
                  vs_first, vs_cnt, act_cnt, bad, gmin, gmax);
        chk(pix == 95, "R10", "new line length from next frame", pix, 95);
        chk(hs_first == 16 && hs_cnt == 3, "R10", "new hsync placement", hs_first * 100 + hs_cnt, 1603);
        chk(lines == 5 && clks == 95, "R10", "address 3 ignored", lines * 1000 + clks, 5095);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule